// File: doc/BRIEF.md
# Local Bus Request/Grant Arbiter

This block is the processor-side logic that lends the local bus to other bus masters. It serves several request/grant channels. Each channel has one active-low line that both sides share. The line is modelled as an input that shows the line level and an output-enable with a drive value. An exchange of the bus uses three one-clock low pulses:

1. The other master pulses the line to request the bus.
2. This block pulses the line back to grant it.
3. The other master pulses the line a third time to hand the bus back.

The block watches the processor's bus-cycle phase and its lock, interrupt-acknowledge and split-word flags, so that it never interrupts a transfer that must not be broken. It raises a float signal while the bus is lent out. When the bus comes back it gives a one-clock reclaim pulse, and a flag that says whether the processor resumes at the start of a new cycle (T1) or at the end phase (T4).

Top module: `rg_arbiter`

## Requirements
- R1: After reset, no line is driven, and `bus_float_o`, `bus_reclaim_o` and `resume_t1_o` are low.
- R2: A request pulse sampled in an idle clock (bus state 0) causes a grant on the same channel in the next clock, if the bus is still idle and unlocked. `bus_float_o` is high from the clock after the grant.
- R3: A grant is one clock wide, drives the line low (`rq_drv_o` bit 0 where `rq_oe_o` is set), goes to at most one channel, and appears only while the bus state is idle (0) or T4 (5).
- R4: A request sampled while the bus state is idle (0), T1 (1) or T2 (2) is granted in the T4 (5) clock of the cycle in progress.
- R5: A request sampled in T3 (3), wait (4) or T4 (5) gets no grant in the T4 of that cycle. It waits for the T4 of the next cycle that starts with T1.
- R6: No grant is given in T4 when `word_lo_i` or `inta_first_i` is high, and none at all while `lock_i` is high. The request stays pending and is granted at a later T4 or idle clock with those flags low.
- R7: A low pulse from the owning channel while the bus floats is a release. At the next edge `bus_float_o` falls, `bus_reclaim_o` is high for one clock, and `resume_t1_o` takes the inverse of `cycle_pending_i` as sampled with the release.
- R8: No grant is given in the clock in which `bus_reclaim_o` is high. This is the idle clock that follows each exchange.
- R9: Lower channel index has priority. When channels 0 and 1 request in the same clock, channel 0 is granted. Channel 1 stays pending and is granted after channel 0 returns the bus.
- R10: The block's own grant pulse, read back on the line, is not taken as a new request or as a release. A pulse from another channel while the bus floats is held as a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_state_i | input | 3 | Bus phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4 |
| lock_i | input | 1 | Locked instruction in progress |
| inta_first_i | input | 1 | Current cycle is the first interrupt-acknowledge |
| word_lo_i | input | 1 | Current cycle is the first half of a split word |
| cycle_pending_i | input | 1 | Processor has a bus cycle waiting to run |
| rq_n_i | input | N_CH | Level of each request/grant line |
| rq_oe_o | output | N_CH | Drive enable for each line (grant pulse) |
| rq_drv_o | output | N_CH | Value driven when enabled (always low) |
| bus_float_o | output | 1 | Bus is lent to another master |
| bus_reclaim_o | output | 1 | One-clock pulse when the bus returns |
| resume_t1_o | output | 1 | Processor resumes at T1 (no cycle pending at release) |

## Verification
Each channel's pending and eligible bits are hidden. A wrong pending bit shows up as a missing or extra grant pulse at the first T4 or idle clock where the block may grant. A wrong eligible bit shows up as a grant moved by one whole bus cycle. A stuck ownership register shows at once as a float that never falls or a reclaim pulse that never comes after the release. A wrong gap counter shows as a grant in the reclaim clock itself. The directed scenarios place each pulse in the clock that tells apart these off-by-one-cycle faults.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_T3   = 3'd3,
    BS_TW   = 3'd4,
    BS_T4   = 3'd5
  } bus_state_e;
endpackage

// File: rtl/rg_chan_track.sv
module rg_chan_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic early_i,
  input  logic new_cycle_i,
  input  logic clr_i,
  output logic pend_o,
  output logic elig_o
);
  logic pend_q, elig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      elig_q <= 1'b0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
      elig_q <= 1'b0;
    end else if (req_i) begin
      pend_q <= 1'b1;
      elig_q <= elig_q | early_i;
    end else if (pend_q && new_cycle_i) begin
      // a request that missed T2 becomes eligible once a fresh cycle starts
      elig_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign elig_o = elig_q;
endmodule

// File: rtl/rg_grant_sel.sv
module rg_grant_sel #(
  parameter int N_CH = 2
) (
  input  logic [N_CH-1:0] cand_i,
  output logic [N_CH-1:0] grant_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (cand_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rg_float_ctrl.sv
module rg_float_ctrl #(
  parameter int N_CH       = 2,
  parameter int GAP_CYCLES = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] grant_i,
  input  logic [N_CH-1:0] line_low_i,
  input  logic            cycle_pending_i,
  output logic [N_CH-1:0] owner_o,
  output logic            float_o,
  output logic            reclaim_o,
  output logic            resume_t1_o,
  output logic            gap_busy_o
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  logic [N_CH-1:0] owner_q;
  logic            reclaim_q, resume_q;
  logic [GW-1:0]   gap_q;
  logic            release_w;

  assign release_w = |(owner_q & line_low_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q   <= '0;
      reclaim_q <= 1'b0;
      resume_q  <= 1'b0;
      gap_q     <= '0;
    end else begin
      reclaim_q <= 1'b0;
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (|grant_i) begin
        owner_q <= grant_i;
      end else if (release_w) begin
        owner_q   <= '0;
        reclaim_q <= 1'b1;
        resume_q  <= !cycle_pending_i;
        gap_q     <= GW'(GAP_CYCLES);
      end
    end
  end

  assign owner_o     = owner_q;
  assign float_o     = |owner_q;
  assign reclaim_o   = reclaim_q;
  assign resume_t1_o = resume_q;
  assign gap_busy_o  = (gap_q != '0);
endmodule

// File: rtl/rg_arbiter.sv
module rg_arbiter
  import rg_pkg::*;
#(
  parameter int N_CH       = 2,
  parameter int GAP_CYCLES = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      bus_state_i,
  input  logic            lock_i,
  input  logic            inta_first_i,
  input  logic            word_lo_i,
  input  logic            cycle_pending_i,
  input  logic [N_CH-1:0] rq_n_i,
  output logic [N_CH-1:0] rq_oe_o,
  output logic [N_CH-1:0] rq_drv_o,
  output logic            bus_float_o,
  output logic            bus_reclaim_o,
  output logic            resume_t1_o
);
  bus_state_e      bs;
  logic [N_CH-1:0] line_low, req_vec, pend, elig, cand, grant, owner;
  logic            early, new_cycle, t4_ok, idle_ok, floated, gap_busy;

  assign bs        = bus_state_e'(bus_state_i);
  assign line_low  = ~rq_n_i;
  assign early     = (bs == BS_IDLE) || (bs == BS_T1) || (bs == BS_T2);
  assign new_cycle = (bs == BS_T1);
  assign t4_ok     = (bs == BS_T4) && !word_lo_i && !inta_first_i;
  assign idle_ok   = (bs == BS_IDLE);

  // own grant echo and the owner's release are not requests
  assign req_vec = line_low & ~grant & ~owner;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    rg_chan_track u_trk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_vec[i]),
      .early_i     (early),
      .new_cycle_i (new_cycle),
      .clr_i       (grant[i]),
      .pend_o      (pend[i]),
      .elig_o      (elig[i])
    );
    assign cand[i] = !floated && !gap_busy && !lock_i &&
                     ((t4_ok && pend[i] && elig[i]) || (idle_ok && pend[i]));
  end

  rg_grant_sel #(.N_CH(N_CH)) u_sel (
    .cand_i  (cand),
    .grant_o (grant)
  );

  rg_float_ctrl #(.N_CH(N_CH), .GAP_CYCLES(GAP_CYCLES)) u_flt (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .grant_i         (grant),
    .line_low_i      (line_low),
    .cycle_pending_i (cycle_pending_i),
    .owner_o         (owner),
    .float_o         (floated),
    .reclaim_o       (bus_reclaim_o),
    .resume_t1_o     (resume_t1_o),
    .gap_busy_o      (gap_busy)
  );

  assign rq_oe_o     = grant;
  assign rq_drv_o    = '0;
  assign bus_float_o = floated;
endmodule

// File: rtl/rg_arbiter_chk.sv
module rg_arbiter_chk #(
  parameter int N_CH = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      bus_state_i,
  input logic            lock_i,
  input logic            inta_first_i,
  input logic            word_lo_i,
  input logic [N_CH-1:0] rq_oe_o,
  input logic [N_CH-1:0] rq_drv_o,
  input logic            bus_float_o,
  input logic            bus_reclaim_o
);
  // R3
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rq_oe_o));
  // R3
  grant_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rq_oe_o) |-> (bus_state_i == 3'd0 || bus_state_i == 3'd5));
  // R3
  grant_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rq_oe_o) |=> (rq_oe_o == '0));
  // R3
  grant_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rq_oe_o) |-> ((rq_drv_o & rq_oe_o) == '0));
  // R2
  float_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rq_oe_o) |=> bus_float_o);
  // R6
  lock_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> (rq_oe_o == '0));
  // R6
  split_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_state_i == 3'd5 && (word_lo_i || inta_first_i)) |-> (rq_oe_o == '0));
  // R7
  reclaim_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_float_o) |-> bus_reclaim_o);
  // R8
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reclaim_o |-> (rq_oe_o == '0));
  // R10
  no_grant_floated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_float_o |-> (rq_oe_o == '0));
endmodule

bind rg_arbiter rg_arbiter_chk #(.N_CH(N_CH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_state_i   (bus_state_i),
  .lock_i        (lock_i),
  .inta_first_i  (inta_first_i),
  .word_lo_i     (word_lo_i),
  .rq_oe_o       (rq_oe_o),
  .rq_drv_o      (rq_drv_o),
  .bus_float_o   (bus_float_o),
  .bus_reclaim_o (bus_reclaim_o)
);

// File: tb/sim_rg_arbiter.sv
`timescale 1ns/100ps
module sim_rg_arbiter;
  localparam logic [2:0] IDLE = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3, T4 = 3'd5;
  localparam logic [1:0] NONE = 2'b11, C0 = 2'b10, C1 = 2'b01, BOTH = 2'b00;
  // flag order {lock, inta_first, word_lo, cycle_pending}
  localparam logic [3:0] F0 = 4'b0000, FLK = 4'b1000, FIN = 4'b0100, FWL = 4'b0010, FCP = 4'b0001;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_state = IDLE;
  logic       lock = 1'b0, inta = 1'b0, wlo = 1'b0, cpend = 1'b0;
  logic [1:0] rq_n = NONE, oe, drv;
  logic       flt, recl, rt1;
  int         errors = 0, checks = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  rg_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_state_i(bus_state), .lock_i(lock),
    .inta_first_i(inta), .word_lo_i(wlo), .cycle_pending_i(cpend),
    .rq_n_i(rq_n), .rq_oe_o(oe), .rq_drv_o(drv), .bus_float_o(flt),
    .bus_reclaim_o(recl), .resume_t1_o(rt1)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: inputs applied after the edge, outputs sampled 1ns later
  task automatic cyc(input logic [2:0] bs, input logic [1:0] rq, input logic [3:0] fl);
    @(posedge clk);
    #1;
    bus_state = bs; rq_n = rq;
    {lock, inta, wlo, cpend} = fl;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_state = IDLE; rq_n = NONE; {lock, inta, wlo, cpend} = F0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // owner of channel mask ch hands the bus back; cp is cycle_pending at release
  task automatic give_back(input logic [1:0] ch, input logic cp, input string req);
    cyc(IDLE, ch, {3'b000, cp});
    chk({7'd0, flt}, 8'd1, req);
    cyc(IDLE, NONE, F0);
    chk({7'd0, flt}, 8'd0, req);
    chk({7'd0, recl}, 8'd1, req);
    chk({7'd0, rt1}, {7'd0, !cp}, req);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk({6'd0, oe}, 8'd0, "R1");
    chk({7'd0, flt}, 8'd0, "R1");
    chk({7'd0, recl}, 8'd0, "R1");
    chk({7'd0, rt1}, 8'd0, "R1");
  endtask

  task automatic t_idle();
    do_reset();
    cyc(IDLE, C0, F0);
    chk({6'd0, oe}, 8'd0, "R2");
    cyc(IDLE, NONE, F0);
    chk({6'd0, oe}, 8'd1, "R2");
    chk({6'd0, drv & oe}, 8'd0, "R3");
    chk({7'd0, flt}, 8'd0, "R2");
    cyc(IDLE, NONE, F0);
    chk({6'd0, oe}, 8'd0, "R3");
    chk({7'd0, flt}, 8'd1, "R2");
    give_back(C0, 1'b0, "R7");
    cyc(IDLE, NONE, F0);
    chk({7'd0, recl}, 8'd0, "R7");
    chk({6'd0, oe}, 8'd0, "R7");
  endtask

  task automatic t_active();
    do_reset();
    cyc(T1, C0, F0);
    cyc(T2, NONE, F0);
    chk({6'd0, oe}, 8'd0, "R4");
    cyc(T3, NONE, F0);
    chk({6'd0, oe}, 8'd0, "R4");
    cyc(T4, NONE, F0);
    chk({6'd0, oe}, 8'd1, "R4");
    cyc(IDLE, NONE, F0);
    chk({7'd0, flt}, 8'd1, "R4");
    give_back(C0, 1'b1, "R7");
  endtask

  task automatic t_late();
    do_reset();
    cyc(T1, NONE, F0);
    cyc(T2, NONE, F0);
    cyc(T3, C0, F0);
    cyc(T4, NONE, F0);
    chk({6'd0, oe}, 8'd0, "R5");
    cyc(T1, NONE, F0);
    cyc(T2, NONE, F0);
    cyc(T3, NONE, F0);
    cyc(T4, NONE, F0);
    chk({6'd0, oe}, 8'd1, "R5");
    cyc(IDLE, NONE, F0);
    give_back(C0, 1'b0, "R5");
  endtask

  task automatic t_block();
    do_reset();
    cyc(T1, C1, F0);
    cyc(T2, NONE, FWL);
    cyc(T3, NONE, FWL);
    cyc(T4, NONE, FWL);
    chk({6'd0, oe}, 8'd0, "R6 word_lo");
    cyc(T1, NONE, FIN);
    cyc(T2, NONE, FIN);
    cyc(T3, NONE, FIN);
    cyc(T4, NONE, FIN);
    chk({6'd0, oe}, 8'd0, "R6 inta_first");
    cyc(T1, NONE, FLK);
    cyc(T2, NONE, FLK);
    cyc(T4, NONE, FLK);
    chk({6'd0, oe}, 8'd0, "R6 lock T4");
    cyc(IDLE, NONE, FLK);
    chk({6'd0, oe}, 8'd0, "R6 lock idle");
    cyc(IDLE, NONE, F0);
    chk({6'd0, oe}, 8'd2, "R6 kept pending");
    cyc(IDLE, NONE, F0);
    give_back(C1, 1'b0, "R6");
  endtask

  task automatic t_prio();
    do_reset();
    cyc(IDLE, BOTH, F0);
    cyc(IDLE, NONE, F0);
    chk({6'd0, oe}, 8'd1, "R9");
    cyc(IDLE, NONE, F0);
    chk({7'd0, flt}, 8'd1, "R9");
    cyc(IDLE, C0, F0);
    cyc(IDLE, NONE, F0);
    chk({7'd0, recl}, 8'd1, "R8");
    chk({6'd0, oe}, 8'd0, "R8");
    cyc(IDLE, NONE, F0);
    chk({6'd0, oe}, 8'd2, "R9");
    cyc(IDLE, NONE, F0);
    give_back(C1, 1'b0, "R9");
  endtask

  task automatic t_echo();
    do_reset();
    cyc(IDLE, C0, F0);
    cyc(IDLE, C0, F0);           // line reads back the block's own grant
    chk({6'd0, oe}, 8'd1, "R10");
    cyc(IDLE, NONE, F0);
    chk({7'd0, flt}, 8'd1, "R10 echo not release");
    cyc(IDLE, C1, F0);           // other channel asks while floated
    chk({7'd0, flt}, 8'd1, "R10");
    give_back(C0, 1'b0, "R10");
    cyc(IDLE, NONE, F0);
    chk({6'd0, oe}, 8'd2, "R10 held request, no echo request");
    cyc(IDLE, NONE, F0);
    give_back(C1, 1'b0, "R10");
    cyc(IDLE, NONE, F0);
    cyc(IDLE, NONE, F0);
    chk({6'd0, oe}, 8'd0, "R10 no stray grant");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_active();
    t_late();
    t_block();
    t_prio();
    t_echo();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule